// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Line Controller

This block turns 23 slow, asynchronous signals into latched interrupt requests for a downstream priority arbiter. Lines 0 to 15 each pick one general-purpose I/O port through a 4-bit selector. Line n always takes pin n of the port it picks. Lines 16 to 22 take internal event inputs directly. Every line passes through a two-stage synchronizer. The line then compares its newest synchronized sample with the one before, and a rising or falling edge can set that line's sticky pending flag, as the line's two trigger enables allow.

Software works the block through a small register port. A write takes one cycle, and a read returns the contents combinationally. Software enables lines with the mask, picks the edge polarity, and acknowledges a request by writing 1 to its pending bit. The pending flags, gated by the mask, drive eight interrupt outputs. Lines 0 to 4 each have a dedicated output. Lines 5 to 9, 10 to 15 and 16 to 22 each share one output, and a handler on a shared output reads the pending register to find which line fired.

Top module: `xirq_line_ctrl`

## Requirements
- R1: After a synchronous reset every register reads zero and all interrupt outputs are low: every line is masked, has no trigger selected, has nothing pending, and selects port 0.
- R2: With a line's rising enable set (register 1, bit = line number), a 0-to-1 change on the line's input, driven before clock edge k, sets its pending bit at edge k+2. The bit is not set earlier.
- R3: With a line's falling enable set (register 2, bit = line number), a 1-to-0 change sets its pending bit with the same latency as R2. A rising change on a line with only falling enabled leaves its pending bit clear.
- R4: With both enables set, each edge of either direction sets the pending bit. With neither set, no change on the line sets it.
- R5: Pending bits are set whatever the mask (register 0) holds. An interrupt output only goes high for a line whose mask bit is 1, and it follows a mask write in the same cycle as the register update.
- R6: Writing register 3 clears every pending bit written as 1. Bits written as 0 keep their value. Reading register 3 returns the pending bits.
- R7: When an edge that would set a pending bit reaches the flag in the same cycle as a write of 1 to that bit, the bit stays set.
- R8: irq[0] to irq[4] follow lines 0 to 4 (pending AND mask). irq[5] is the OR of lines 5 to 9, irq[6] the OR of lines 10 to 15, and irq[7] the OR of lines 16 to 22.
- R9: Registers 4 to 7 hold the port selectors. Line n uses register 4 + n/4, bits [4*(n%4)+3 : 4*(n%4)]. Selector value p makes line n sample gpio_in[16*p + n], so 0 picks port A and 2 picks port C. Values of 9 or more feed a constant 0. Pins of ports that are not selected have no effect.
- R10: Line 16+e takes evt_in[e] and bypasses the port selectors. Register addresses 8 to 15 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 144 | Nine 16-pin ports, port p at bits [16p+15:16p] |
| evt_in | input | 7 | Internal event inputs for lines 16 to 22 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq | output | 8 | Interrupt requests toward the arbiter |

## Verification
A detected edge and a software write-1-to-clear can land on the same pending bit in the same cycle. Only the setting edge may win. The bench produces this case by raising a line two cycles before a clear write, so the synchronized edge reaches the flag at the very edge where the write lands. It then reads the pending register to confirm the bit survived, and a later clear without an edge confirms the bit can still be cleared. The random phase keeps toggling pins and clearing bits, so the same collision also arises unplanned. A cycle-accurate bench model judges the outcome by reading back registers and watching irq.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
package xirq_pkg;

    localparam int unsigned REG_AW        = 4;
    localparam int unsigned REG_DW        = 32;
    localparam int unsigned SEL_W         = 4;
    localparam int unsigned SEL_PER_REG   = 4;
    localparam int unsigned PINS_PER_PORT = 16;
    localparam int unsigned NUM_IRQ       = 8;

    typedef enum logic [REG_AW-1:0] {
        RA_MASK = 4'd0,
        RA_RISE = 4'd1,
        RA_FALL = 4'd2,
        RA_PEND = 4'd3,
        RA_SEL0 = 4'd4
    } reg_addr_e;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] wdata;
    } reg_req_t;

    // Output slot that a line feeds: dedicated for 0..4, then three shared groups.
    function automatic int unsigned irq_slot(input int unsigned line);
        if (line < 5)  return line;
        if (line < 10) return 5;
        if (line < 16) return 6;
        return 7;
    endfunction

endpackage

// File: rtl/xirq_port_mux.sv
`timescale 1ns/1ps
module xirq_port_mux import xirq_pkg::*; #(
    parameter int unsigned NUM_PORTS = 9,
    parameter int unsigned PIN_LINES = 16,
    parameter int unsigned EVT_LINES = 7
) (
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0] gpio_in,
    input  logic [EVT_LINES-1:0]               evt_in,
    input  logic [PIN_LINES*SEL_W-1:0]         sel_flat,
    output logic [PIN_LINES+EVT_LINES-1:0]     line_raw
);
    localparam int unsigned NUM_LINES = PIN_LINES + EVT_LINES;

    for (genvar n = 0; n < PIN_LINES; n++) begin : g_pin
        always_comb begin
            line_raw[n] = 1'b0;
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (sel_flat[n*SEL_W +: SEL_W] == SEL_W'(p))
                    line_raw[n] = gpio_in[p*PINS_PER_PORT + n];
            end
        end
    end

    assign line_raw[NUM_LINES-1:PIN_LINES] = evt_in;

endmodule

// File: rtl/xirq_sync_edge.sv
`timescale 1ns/1ps
module xirq_sync_edge #(
    parameter int unsigned W = 23
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stage1_q, stage2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
            prev_q   <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign rise = stage2_q & ~prev_q;
    assign fall = ~stage2_q & prev_q;

    // R2: a rising report needs the raw input high two edges earlier
    p_rise_source_r2: assert property (@(posedge clk) disable iff (rst)
        (rise & ~$past(din, 2)) == '0);

    // R3: a falling report needs the raw input low two edges earlier
    p_fall_source_r3: assert property (@(posedge clk) disable iff (rst)
        (fall & $past(din, 2)) == '0);

endmodule

// File: rtl/xirq_regs.sv
`timescale 1ns/1ps
module xirq_regs import xirq_pkg::*; #(
    parameter int unsigned NUM_LINES = 23,
    parameter int unsigned PIN_LINES = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  reg_req_t                   req,
    output logic [REG_DW-1:0]          rdata,
    input  logic [NUM_LINES-1:0]       rise_ev,
    input  logic [NUM_LINES-1:0]       fall_ev,
    output logic [NUM_LINES-1:0]       mask_q,
    output logic [NUM_LINES-1:0]       pend_q,
    output logic [PIN_LINES*SEL_W-1:0] sel_flat
);
    localparam int unsigned NUM_SEL_REGS = (PIN_LINES + SEL_PER_REG - 1) / SEL_PER_REG;

    logic [NUM_LINES-1:0] rise_en_q, fall_en_q, wdata_l, hit, clr;
    logic wr_mask, wr_rise, wr_fall, wr_pend;
    logic unused_wdata_hi;

    assign wdata_l         = req.wdata[NUM_LINES-1:0];
    assign unused_wdata_hi = ^req.wdata[REG_DW-1:NUM_LINES];
    assign wr_mask = req.we && (req.addr == RA_MASK);
    assign wr_rise = req.we && (req.addr == RA_RISE);
    assign wr_fall = req.we && (req.addr == RA_FALL);
    assign wr_pend = req.we && (req.addr == RA_PEND);

    assign hit = (rise_ev & rise_en_q) | (fall_ev & fall_en_q);
    assign clr = wr_pend ? wdata_l : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
            pend_q    <= '0;
        end else begin
            if (wr_mask) mask_q    <= wdata_l;
            if (wr_rise) rise_en_q <= wdata_l;
            if (wr_fall) fall_en_q <= wdata_l;
            // a set in the same cycle as a clear takes precedence
            pend_q <= (pend_q & ~clr) | hit;
        end
    end

    for (genvar n = 0; n < PIN_LINES; n++) begin : g_sel
        localparam int unsigned SEL_ADDR = int'(RA_SEL0) + n / SEL_PER_REG;
        localparam int unsigned SEL_LSB  = (n % SEL_PER_REG) * SEL_W;
        logic [SEL_W-1:0] sel_q;
        always_ff @(posedge clk) begin
            if (rst)
                sel_q <= '0;
            else if (req.we && (req.addr == REG_AW'(SEL_ADDR)))
                sel_q <= req.wdata[SEL_LSB +: SEL_W];
        end
        assign sel_flat[n*SEL_W +: SEL_W] = sel_q;
    end

    always_comb begin
        rdata = '0;
        unique case (req.addr)
            RA_MASK: rdata[NUM_LINES-1:0] = mask_q;
            RA_RISE: rdata[NUM_LINES-1:0] = rise_en_q;
            RA_FALL: rdata[NUM_LINES-1:0] = fall_en_q;
            RA_PEND: rdata[NUM_LINES-1:0] = pend_q;
            default: begin
                for (int k = 0; k < NUM_SEL_REGS; k++) begin
                    if (req.addr == REG_AW'(int'(RA_SEL0) + k)) begin
                        for (int j = 0; j < SEL_PER_REG; j++) begin
                            if (k*SEL_PER_REG + j < PIN_LINES)
                                rdata[j*SEL_W +: SEL_W] =
                                    sel_flat[(k*SEL_PER_REG + j)*SEL_W +: SEL_W];
                        end
                    end
                end
            end
        endcase
    end

    // R2: a pending bit only rises after an enabled edge reached it
    p_set_needs_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (pend_q & ~$past(pend_q) & ~$past(hit)) == '0);

    // R6: a pending bit only falls after a write of 1 to it
    p_clear_needs_w1c_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(pend_q) & ~pend_q & ~$past(clr)) == '0);

    // R7: an edge colliding with a clear leaves the bit set
    p_edge_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_pend && |(wdata_l & hit)) |=>
        ((pend_q & $past(wdata_l & hit)) == $past(wdata_l & hit)));

endmodule

// File: rtl/xirq_irq_map.sv
`timescale 1ns/1ps
module xirq_irq_map import xirq_pkg::*; #(
    parameter int unsigned NUM_LINES = 23
) (
    input  logic [NUM_LINES-1:0] pend_q,
    input  logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_IRQ-1:0]   irq
);
    logic [NUM_LINES-1:0] live;
    assign live = pend_q & mask_q;

    for (genvar o = 0; o < NUM_IRQ; o++) begin : g_out
        always_comb begin
            irq[o] = 1'b0;
            for (int l = 0; l < NUM_LINES; l++) begin
                if (irq_slot(l) == o) irq[o] = irq[o] | live[l];
            end
        end
    end

endmodule

// File: rtl/xirq_line_ctrl.sv
`timescale 1ns/1ps
module xirq_line_ctrl import xirq_pkg::*; #(
    parameter int unsigned NUM_PORTS = 9,
    parameter int unsigned PIN_LINES = 16,
    parameter int unsigned EVT_LINES = 7
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [NUM_PORTS*PINS_PER_PORT-1:0] gpio_in,
    input  logic [EVT_LINES-1:0]               evt_in,
    input  logic                               reg_wr,
    input  logic [REG_AW-1:0]                  reg_addr,
    input  logic [REG_DW-1:0]                  reg_wdata,
    output logic [REG_DW-1:0]                  reg_rdata,
    output logic [NUM_IRQ-1:0]                 irq
);
    localparam int unsigned NUM_LINES = PIN_LINES + EVT_LINES;

    reg_req_t             req;
    logic [NUM_LINES-1:0] line_raw, rise_ev, fall_ev, mask_q, pend_q;
    logic [PIN_LINES*SEL_W-1:0] sel_flat;

    assign req = '{we: reg_wr, addr: reg_addr, wdata: reg_wdata};

    xirq_port_mux #(
        .NUM_PORTS(NUM_PORTS), .PIN_LINES(PIN_LINES), .EVT_LINES(EVT_LINES)
    ) u_mux (
        .gpio_in(gpio_in), .evt_in(evt_in), .sel_flat(sel_flat), .line_raw(line_raw)
    );

    xirq_sync_edge #(.W(NUM_LINES)) u_edge (
        .clk(clk), .rst(rst), .din(line_raw), .rise(rise_ev), .fall(fall_ev)
    );

    xirq_regs #(.NUM_LINES(NUM_LINES), .PIN_LINES(PIN_LINES)) u_regs (
        .clk(clk), .rst(rst), .req(req), .rdata(reg_rdata),
        .rise_ev(rise_ev), .fall_ev(fall_ev),
        .mask_q(mask_q), .pend_q(pend_q), .sel_flat(sel_flat)
    );

    xirq_irq_map #(.NUM_LINES(NUM_LINES)) u_map (
        .pend_q(pend_q), .mask_q(mask_q), .irq(irq)
    );

    // R5: no output without an unmasked pending line behind it
    p_irq_needs_live_r5: assert property (@(posedge clk) disable iff (rst)
        (|irq) |-> (|(pend_q & mask_q)));

    // R8: the shared output of lines 5..9 is backed by one of them
    p_shared_group_r8: assert property (@(posedge clk) disable iff (rst)
        irq[5] |-> (|(pend_q[9:5] & mask_q[9:5])));

endmodule

// File: tb/xirq_line_ctrl_bench.sv
`timescale 1ns/1ps
module xirq_line_ctrl_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [143:0] gpio_in = '0;
    logic [6:0]   evt_in = '0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [7:0]   irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    xirq_line_ctrl u_xirq_line_ctrl (
        .clk(clk), .rst(rst), .gpio_in(gpio_in), .evt_in(evt_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    // bench model of the requirements
    logic [22:0] m_mask = '0, m_rise = '0, m_fall = '0, m_pend = '0;
    logic [22:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
    logic [3:0]  m_sel [16];

    function automatic logic [22:0] model_lines();
        logic [22:0] v = '0;
        for (int n = 0; n < 16; n++) begin
            int p = int'(m_sel[n]);
            v[n] = (p < 9) ? gpio_in[p*16 + n] : 1'b0;   // R9
        end
        for (int e = 0; e < 7; e++) v[16+e] = evt_in[e];  // R10
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] r = '0;
        case (a)
            4'd0: r[22:0] = m_mask;
            4'd1: r[22:0] = m_rise;
            4'd2: r[22:0] = m_fall;
            4'd3: r[22:0] = m_pend;
            4'd4, 4'd5, 4'd6, 4'd7:
                for (int j = 0; j < 4; j++) r[j*4 +: 4] = m_sel[(int'(a)-4)*4 + j];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [7:0] model_irq();
        logic [22:0] a = m_pend & m_mask;
        logic [7:0] o;
        o[4:0] = a[4:0];
        o[5] = |a[9:5];
        o[6] = |a[15:10];
        o[7] = |a[22:16];
        return o;
    endfunction

    task automatic model_tick();
        logic [22:0] ln, r, f, np;
        if (rst) begin
            m_mask = '0; m_rise = '0; m_fall = '0; m_pend = '0;
            m_s1 = '0; m_s2 = '0; m_prev = '0;
            for (int n = 0; n < 16; n++) m_sel[n] = '0;
        end else begin
            ln = model_lines();
            r  = m_s2 & ~m_prev;
            f  = ~m_s2 & m_prev;
            np = m_pend;
            if (reg_wr && reg_addr == 4'd3) np = np & ~reg_wdata[22:0];
            np = np | (r & m_rise) | (f & m_fall);
            if (reg_wr) begin
                case (reg_addr)
                    4'd0: m_mask = reg_wdata[22:0];
                    4'd1: m_rise = reg_wdata[22:0];
                    4'd2: m_fall = reg_wdata[22:0];
                    4'd4, 4'd5, 4'd6, 4'd7:
                        for (int j = 0; j < 4; j++)
                            m_sel[(int'(reg_addr)-4)*4 + j] = reg_wdata[j*4 +: 4];
                    default: ;
                endcase
            end
            m_pend = np;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = ln;
        end
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_tick();
        @(negedge clk);
        chk("R5/R8 irq vs model", {24'd0, irq}, {24'd0, model_irq()});
        chk("R6/R9/R10 read vs model", reg_rdata, model_read(reg_addr));
    endtask

    task automatic cyc3();
        repeat (3) cyc();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        for (int n = 0; n < 16; n++) m_sel[n] = '0;
        void'($urandom(32'h1a2b3c4d));
        repeat (3) cyc();
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq after reset", {24'd0, irq}, 32'd0);
        for (int a = 0; a < 8; a++) rd_chk("R1 register after reset", 4'(a), 32'd0);

        // R2 rising edge latency on line 0
        wr(4'd1, 32'h1);
        wr(4'd0, 32'h1);
        gpio_in[0] = 1'b1;
        cyc(); cyc();
        chk("R2 not yet pending after two edges", {31'd0, irq[0]}, 32'd0);
        cyc();
        chk("R2 pending at third edge", {31'd0, irq[0]}, 32'd1);

        // R7 edge and clear in the same cycle
        gpio_in[0] = 1'b0;
        cyc3();
        gpio_in[0] = 1'b1;
        cyc(); cyc();
        wr(4'd3, 32'h1);
        rd_chk("R7 edge wins over clear", 4'd3, 32'h1);

        // R6 write-0 no effect, write-1 clears
        wr(4'd0, 32'h1);
        wr(4'd3, 32'h0);
        rd_chk("R6 zero write keeps pending", 4'd3, 32'h1);
        wr(4'd3, 32'h1);
        rd_chk("R6 one write clears", 4'd3, 32'h0);
        chk("R6 irq low after clear", {31'd0, irq[0]}, 32'd0);

        // R4 both edges on line 1
        wr(4'd1, 32'h3);
        wr(4'd2, 32'h2);
        wr(4'd0, 32'h3);
        gpio_in[1] = 1'b1;
        cyc3();
        chk("R4 rising with both enabled", {31'd0, irq[1]}, 32'd1);
        wr(4'd3, 32'h2);
        gpio_in[1] = 1'b0;
        cyc3();
        chk("R4 falling with both enabled", {31'd0, irq[1]}, 32'd1);
        wr(4'd3, 32'h2);

        // R3 falling only on line 2, mask off (R5)
        wr(4'd2, 32'h6);
        gpio_in[2] = 1'b1;
        cyc3();
        rd_chk("R3 rise ignored with falling only", 4'd3, 32'h0);
        gpio_in[2] = 1'b0;
        cyc3();
        rd_chk("R3 falling sets pending", 4'd3, 32'h4);
        chk("R5 masked line keeps irq low", {31'd0, irq[2]}, 32'd0);
        wr(4'd0, 32'h7);
        chk("R5 unmask raises irq", {31'd0, irq[2]}, 32'd1);
        wr(4'd3, 32'h7fffff);

        // R4 neither enabled on line 3
        gpio_in[3] = 1'b1; cyc3(); gpio_in[3] = 1'b0; cyc3();
        rd_chk("R4 no enable no pending", 4'd3, 32'h0);

        // R9 port C pin 6 on line 6
        gpio_in[38] = 1'b1;
        wr(4'd5, 32'h0000_0200);
        rd_chk("R9 selector field readback", 4'd5, 32'h0000_0200);
        cyc3();
        wr(4'd2, 32'h46);
        wr(4'd0, 32'h47);
        wr(4'd3, 32'h7fffff);
        gpio_in[6] = 1'b1; cyc3(); gpio_in[6] = 1'b0; cyc3();
        chk("R9 unselected port ignored", {31'd0, irq[5]}, 32'd0);
        gpio_in[38] = 1'b0;
        cyc3();
        chk("R9 port C pin drives line 6", {24'd0, irq}, 32'h20);
        wr(4'd3, 32'h7fffff);

        // R10 event line 16 and R8 grouping of line 12
        wr(4'd1, 32'h1_1003);
        wr(4'd0, 32'h1_1047);
        evt_in[0] = 1'b1;
        cyc3();
        chk("R10 event input on line 16", {24'd0, irq}, 32'h80);
        wr(4'd3, 32'h7fffff);
        gpio_in[12] = 1'b1;
        cyc3();
        chk("R8 line 12 on shared output 6", {24'd0, irq}, 32'h40);
        wr(4'd9, 32'hffff_ffff);
        rd_chk("R10 unused address reads zero", 4'd9, 32'h0);
        wr(4'd3, 32'h7fffff);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 3 == 0) gpio_in[$urandom % 144] ^= 1'b1;
            if ($urandom % 6 == 0) evt_in[$urandom % 7] ^= 1'b1;
            if ($urandom % 6 == 0) begin
                reg_wr = 1'b1;
                reg_addr = 4'($urandom % 10);
                reg_wdata = $urandom;
            end else begin
                reg_wr = 1'b0;
                reg_addr = 4'($urandom % 10);
            end
            cyc();
        end
        reg_wr = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule